// File: doc/BRIEF.md
# Switching Regulator Fault Supervisor

This block is the digital supervisor that sits beside a PWM buck regulator. The analog comparators, the references and the soft-start ramp are outside it. Their results arrive as already-synchronised flags. They are qualified against a one-clock switching-cycle tick, against a high-side sample strobe, or against the system clock.

From these flags the block drives three things:
- a high-side gate inhibit,
- a sticky fault latch, which stops switching until it is cleared,
- the main power-good and the enable for the termination regulator.

Over-current is handled in two phases. First the block skips pulses. Then it opens a watch window, and a repeat of the limit event inside that window latches the fault. Over-voltage is qualified over a run of switching cycles. A shorted feedback pin is detected by its duration in system clocks during soft-start. An over-temperature trip shuts the regulator down. Its release issues a one-clock power-on reset, which clears the fault state and asks for a full soft-start.

Top module: `reg_fault_supervisor`

## Requirements
- R1: A current-limit flag that is high on a switching tick (`cyc_tick` high for one clock) starts a skip phase. `hs_inhibit` is high from the clock after that tick through the tick of cycle 8, where the event tick is cycle 0. It is low again after the tick of cycle 9.
- R2: A current-limit flag on any tick of cycles 9 to 16 after the first event sets `fault_latched` at that tick's clock edge.
- R3: Current-limit flags on cycles 1 to 8 are ignored. With no flag on cycles 9 to 16, the over-current logic returns to idle and no fault is set. A flag on cycle 17 or later starts a fresh skip phase without a fault.
- R4: While `ss_active` is high, a repeated current-limit event in the watch window does not set the fault latch.
- R5: `ovp_det` high on 16 consecutive ticks sets the latch at the 16th tick. A tick with `ovp_det` low restarts the count.
- R6: `hs_err` is sampled only while `hs_sample` is high. A high sample sets the latch. `hs_err` outside the strobe has no effect.
- R7: While `ss_active` is high, `vout_high` and `fb_low` both high for more than SHORT_CLKS consecutive clocks sets the latch. Outside soft-start, the same condition has no effect.
- R8: The over-voltage, high-side and feedback-short faults set the latch even while `ss_active` is high.
- R9: `ot_trip` sets `therm_shut`, which holds `hs_inhibit` high and `pgood` low. When `ot_release` is high while shut down, `therm_shut` clears and `por_pulse` is high for exactly one clock. That pulse clears the fault latch and all qualification state.
- R10: `tt_enable` is high exactly when `sleep_ok` and `pgood` are both high.
- R11: Once set, `fault_latched` stays high, with `hs_inhibit` high and `pgood` low, until `rst_n` goes low or `por_pulse` clears it. A fault that arrives in the same clock as `por_pulse` wins, and the latch stays set.
- R12: `pgood` is `reg_ok` and `enable` with no fault and no thermal shutdown. `enable` low forces `hs_inhibit` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | One-clock pulse at the start of each switching cycle |
| hs_sample | input | 1 | High-side fault sample strobe |
| ilim_det | input | 1 | Current-limit comparator flag |
| ovp_det | input | 1 | Over-voltage comparator flag |
| hs_err | input | 1 | High-side switch fault comparator flag |
| fb_low | input | 1 | Feedback below short threshold |
| vout_high | input | 1 | Regulator output above runaway threshold |
| ss_active | input | 1 | Soft-start in progress |
| ot_trip | input | 1 | Over-temperature trip flag |
| ot_release | input | 1 | Over-temperature release flag |
| sleep_ok | input | 1 | Sleep-state input permitting termination rail |
| enable | input | 1 | Regulator enable |
| reg_ok | input | 1 | Output-in-regulation comparator flag |
| hs_inhibit | output | 1 | High-side gate inhibit |
| fault_latched | output | 1 | Sticky fault latch |
| therm_shut | output | 1 | Thermal shutdown active |
| por_pulse | output | 1 | One-clock power-on reset, soft-start restart request |
| pgood | output | 1 | Main power-good |
| tt_enable | output | 1 | Termination regulator enable |

## Verification
The power-on reset that follows thermal release clears the fault latch. A fresh fault can arrive in that same clock and wants to set it. The bench provokes this by latching a fault, tripping and releasing the thermal flag, and then strobing a high-side error in the exact clock where `por_pulse` is high. The latch is expected to stay set, and `por_pulse` is expected to have been high for one clock only.

The over-current windows are swept by placing the second limit event at every cycle from 1 to 20. Fault and inhibit expectations are derived from the cycle index alone. The duration-qualified faults are checked one count either side of their thresholds.

// File: rtl/rfs_pkg.sv
package rfs_pkg;
   typedef enum logic [1:0] {
      OC_IDLE  = 2'd0,
      OC_SKIP  = 2'd1,
      OC_WATCH = 2'd2,
      OC_FAULT = 2'd3
   } oc_state_e;
endpackage

// File: rtl/rfs_persist_cnt.sv
// Counts consecutive enabled samples with cond high; hit on the LIMIT-th one.
module rfs_persist_cnt #(
   parameter int LIMIT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic en,
   input  logic cond,
   output logic hit
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("rfs_persist_cnt: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   assign hit = en && cond && (cnt_q == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (clr)              cnt_q <= '0;
      else if (en && !cond)      cnt_q <= '0;
      else if (en && !hit)       cnt_q <= cnt_q + 1'b1;
   end

   p_cnt_bounded_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIMIT - 1));
endmodule

// File: rtl/rfs_oc_ctrl.sv
// Over-current pulse skipping with recurrence watch window.
module rfs_oc_ctrl
   import rfs_pkg::*;
#(
   parameter int SKIP_N  = 8,
   parameter int WATCH_N = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic tick,
   input  logic ilim,
   input  logic ss_active,
   output logic skip,
   output logic set_fault
);
   localparam int MAXN = (SKIP_N > WATCH_N) ? SKIP_N : WATCH_N;
   localparam int CW   = $clog2(MAXN + 1);

   if (SKIP_N < 1 || WATCH_N < 2) begin : g_bad_cfg
      $error("rfs_oc_ctrl: SKIP_N >= 1 and WATCH_N >= 2 required");
   end

   oc_state_e     st_q, st_d;
   logic [CW-1:0] cnt_q, cnt_d;

   always_comb begin
      st_d      = st_q;
      cnt_d     = cnt_q;
      set_fault = 1'b0;
      if (tick) begin
         unique case (st_q)
            OC_IDLE: if (ilim) begin
               st_d  = OC_SKIP;
               cnt_d = '0;
            end
            OC_SKIP: if (cnt_q == CW'(SKIP_N)) begin
               cnt_d = '0;
               if (ilim && !ss_active) begin
                  st_d      = OC_FAULT;
                  set_fault = 1'b1;
               end else begin
                  st_d = OC_WATCH;
               end
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
            OC_WATCH: if (cnt_q == CW'(WATCH_N - 1)) begin
               cnt_d = '0;
               st_d  = ilim ? OC_SKIP : OC_IDLE;
            end else if (ilim && !ss_active) begin
               cnt_d     = '0;
               st_d      = OC_FAULT;
               set_fault = 1'b1;
            end else begin
               cnt_d = cnt_q + 1'b1;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= OC_IDLE;
         cnt_q <= '0;
      end else if (clr) begin
         st_q  <= OC_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign skip = (st_q == OC_SKIP);

   p_skip_entry_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OC_SKIP && $past(st_q) == OC_IDLE) |-> $past(tick && ilim));
   p_no_oc_fault_in_ss_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OC_FAULT && $past(st_q) != OC_FAULT) |-> !$past(ss_active));
   p_fault_from_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == OC_FAULT && $past(st_q) != OC_FAULT) |->
         ($past(st_q) == OC_SKIP || $past(st_q) == OC_WATCH));
endmodule

// File: rtl/reg_fault_supervisor.sv
module reg_fault_supervisor #(
   parameter int SKIP_N     = 8,
   parameter int WATCH_N    = 8,
   parameter int OVP_N      = 16,
   parameter int SHORT_CLKS = 3500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_tick,
   input  logic hs_sample,
   input  logic ilim_det,
   input  logic ovp_det,
   input  logic hs_err,
   input  logic fb_low,
   input  logic vout_high,
   input  logic ss_active,
   input  logic ot_trip,
   input  logic ot_release,
   input  logic sleep_ok,
   input  logic enable,
   input  logic reg_ok,
   output logic hs_inhibit,
   output logic fault_latched,
   output logic therm_shut,
   output logic por_pulse,
   output logic pgood,
   output logic tt_enable
);
   localparam int FB_LIMIT = SHORT_CLKS + 1;

   if (OVP_N < 2 || SHORT_CLKS < 1) begin : g_bad_cfg
      $error("reg_fault_supervisor: OVP_N >= 2 and SHORT_CLKS >= 1 required");
   end

   logic oc_skip, oc_fault, ovp_hit, fb_hit, hs_hit, any_fault;
   logic fault_q, shut_q, por_q;

   rfs_oc_ctrl #(.SKIP_N(SKIP_N), .WATCH_N(WATCH_N)) u_oc (
      .clk(clk), .rst_n(rst_n), .clr(por_q), .tick(cyc_tick),
      .ilim(ilim_det), .ss_active(ss_active),
      .skip(oc_skip), .set_fault(oc_fault)
   );

   rfs_persist_cnt #(.LIMIT(OVP_N)) u_ovp (
      .clk(clk), .rst_n(rst_n), .clr(por_q), .en(cyc_tick),
      .cond(ovp_det), .hit(ovp_hit)
   );

   rfs_persist_cnt #(.LIMIT(FB_LIMIT)) u_fbshort (
      .clk(clk), .rst_n(rst_n), .clr(por_q), .en(1'b1),
      .cond(ss_active && vout_high && fb_low), .hit(fb_hit)
   );

   assign hs_hit    = hs_sample && hs_err;
   assign any_fault = oc_fault || ovp_hit || fb_hit || hs_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         shut_q  <= 1'b0;
         por_q   <= 1'b0;
      end else begin
         fault_q <= any_fault || (fault_q && !por_q);
         por_q   <= shut_q && ot_release && !ot_trip;
         if (ot_trip)         shut_q <= 1'b1;
         else if (ot_release) shut_q <= 1'b0;
      end
   end

   assign fault_latched = fault_q;
   assign therm_shut    = shut_q;
   assign por_pulse     = por_q;
   assign pgood         = reg_ok && enable && !fault_q && !shut_q;
   assign tt_enable     = sleep_ok && pgood;
   assign hs_inhibit    = !enable || fault_q || shut_q || oc_skip;

   p_ovp_sets_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ovp_hit |=> fault_latched);
   p_fb_sets_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
      fb_hit |=> fault_latched);
   p_latch_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_latched && !por_pulse) |=> fault_latched);
   p_por_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      por_pulse |=> !por_pulse);
   p_shut_blocks_pgood_r9: assert property (@(posedge clk) disable iff (!rst_n)
      therm_shut |-> (!pgood && hs_inhibit));
endmodule

// File: tb/reg_fault_supervisor_tb.sv
`timescale 1ns/1ps
module reg_fault_supervisor_tb;
   localparam int SC = 20;

   logic clk = 1'b0;
   logic rst_n, cyc_tick, hs_sample, ilim_det, ovp_det, hs_err, fb_low, vout_high;
   logic ss_active, ot_trip, ot_release, sleep_ok, enable, reg_ok;
   logic hs_inhibit, fault_latched, therm_shut, por_pulse, pgood, tt_enable;
   int nchk = 0, nfail = 0;

   always #2 clk = ~clk;

   reg_fault_supervisor #(.SHORT_CLKS(SC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .hs_sample(hs_sample),
      .ilim_det(ilim_det), .ovp_det(ovp_det), .hs_err(hs_err), .fb_low(fb_low),
      .vout_high(vout_high), .ss_active(ss_active), .ot_trip(ot_trip),
      .ot_release(ot_release), .sleep_ok(sleep_ok), .enable(enable), .reg_ok(reg_ok),
      .hs_inhibit(hs_inhibit), .fault_latched(fault_latched), .therm_shut(therm_shut),
      .por_pulse(por_pulse), .pgood(pgood), .tt_enable(tt_enable)
   );

   task automatic chk(input string what, input logic act, input logic exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s act=%0b exp=%0b", what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0; cyc_tick = 0; hs_sample = 0; ilim_det = 0; ovp_det = 0;
      hs_err = 0; fb_low = 0; vout_high = 0; ss_active = 0; ot_trip = 0;
      ot_release = 0; sleep_ok = 1; enable = 1; reg_ok = 1;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic tick(input logic il, input logic ov);
      ilim_det = il; ovp_det = ov; cyc_tick = 1'b1;
      @(negedge clk);
      cyc_tick = 1'b0; ilim_det = 1'b0; ovp_det = 1'b0;
      @(negedge clk);
   endtask

   task automatic hs_strobe(input logic err);
      hs_err = err; hs_sample = 1'b1;
      @(negedge clk);
      hs_sample = 1'b0; hs_err = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(4 * 150000);
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      logic fe;
      do_reset();
      chk("R12 reset fault", fault_latched, 1'b0);
      chk("R12 reset inhibit", hs_inhibit, 1'b0);
      chk("R12 reset pgood", pgood, 1'b1);
      chk("R9 reset por", por_pulse, 1'b0);

      // Over-current: second event at cycle k
      for (int k = 1; k <= 20; k++) begin
         do_reset();
         tick(1'b1, 1'b0);
         chk("R1 skip on event", hs_inhibit, 1'b1);
         for (int j = 1; j < k; j++) begin
            tick(1'b0, 1'b0);
            chk(j <= 8 ? "R1 skip hold" : "R3 skip released", hs_inhibit, j <= 8);
         end
         tick(1'b1, 1'b0);
         fe = (k >= 9 && k <= 16);
         chk("R2 recurrence latch", fault_latched, fe);
         chk("R3 inhibit after second", hs_inhibit, fe || k <= 8 || k >= 17);
         if (fe) chk("R11 pgood low on fault", pgood, 1'b0);
         if (k <= 8) begin
            for (int j = k + 1; j <= 20; j++) tick(1'b0, 1'b0);
            chk("R3 idle no fault", fault_latched, 1'b0);
            chk("R3 idle no inhibit", hs_inhibit, 1'b0);
         end
      end

      // R4: soft-start masks over-current fault
      do_reset();
      ss_active = 1'b1;
      tick(1'b1, 1'b0);
      for (int j = 1; j < 12; j++) tick(1'b0, 1'b0);
      tick(1'b1, 1'b0);
      chk("R4 no oc fault in ss", fault_latched, 1'b0);
      ss_active = 1'b0;

      // R5: over-voltage run lengths
      for (int n = 14; n <= 17; n++) begin
         do_reset();
         for (int j = 0; j < n; j++) tick(1'b0, 1'b1);
         chk("R5 ovp run", fault_latched, n >= 16);
      end
      do_reset();
      for (int j = 0; j < 10; j++) tick(1'b0, 1'b1);
      tick(1'b0, 1'b0);
      for (int j = 0; j < 10; j++) tick(1'b0, 1'b1);
      chk("R5 ovp gap restarts", fault_latched, 1'b0);
      for (int j = 0; j < 6; j++) tick(1'b0, 1'b1);
      chk("R5 ovp after restart", fault_latched, 1'b1);
      do_reset();
      ss_active = 1'b1;
      for (int j = 0; j < 16; j++) tick(1'b0, 1'b1);
      chk("R8 ovp in ss", fault_latched, 1'b1);
      ss_active = 1'b0;

      // R6: high-side sample
      do_reset();
      hs_err = 1'b1;
      repeat (5) @(negedge clk);
      hs_err = 1'b0;
      chk("R6 err without strobe", fault_latched, 1'b0);
      hs_strobe(1'b0);
      chk("R6 strobe without err", fault_latched, 1'b0);
      hs_strobe(1'b1);
      chk("R6 sampled err", fault_latched, 1'b1);
      do_reset();
      ss_active = 1'b1;
      hs_strobe(1'b1);
      chk("R8 hs in ss", fault_latched, 1'b1);
      ss_active = 1'b0;

      // R7: feedback short duration
      for (int i = 0; i < 4; i++) begin
         int len;
         len = (i == 0) ? SC - 1 : (i == 1) ? SC : (i == 2) ? SC + 1 : SC + 5;
         do_reset();
         ss_active = 1'b1; vout_high = 1'b1; fb_low = 1'b1;
         repeat (len) @(negedge clk);
         vout_high = 1'b0; fb_low = 1'b0;
         @(negedge clk);
         chk("R7 fb short length", fault_latched, len > SC);
         chk(i >= 2 ? "R8 fb short in ss" : "R7 below limit", fault_latched, i >= 2);
         ss_active = 1'b0;
      end
      do_reset();
      vout_high = 1'b1; fb_low = 1'b1;
      repeat (SC + 5) @(negedge clk);
      vout_high = 1'b0; fb_low = 1'b0;
      chk("R7 no fb fault outside ss", fault_latched, 1'b0);
      do_reset();
      ss_active = 1'b1; vout_high = 1'b1;
      repeat (SC + 5) @(negedge clk);
      vout_high = 1'b0; ss_active = 1'b0;
      chk("R7 needs both flags", fault_latched, 1'b0);

      // R9 / R11: thermal and latch hold
      do_reset();
      ot_release = 1'b1;
      @(negedge clk);
      ot_release = 1'b0;
      chk("R9 release without trip", por_pulse, 1'b0);
      hs_strobe(1'b1);
      repeat (20) @(negedge clk);
      chk("R11 latch holds", fault_latched, 1'b1);
      chk("R11 inhibit holds", hs_inhibit, 1'b1);
      ot_trip = 1'b1;
      @(negedge clk);
      ot_trip = 1'b0;
      chk("R9 shut set", therm_shut, 1'b1);
      chk("R9 pgood low", pgood, 1'b0);
      ot_release = 1'b1;
      @(negedge clk);
      ot_release = 1'b0;
      chk("R9 shut released", therm_shut, 1'b0);
      chk("R9 por high", por_pulse, 1'b1);
      @(negedge clk);
      chk("R9 por one clock", por_pulse, 1'b0);
      chk("R9 por clears latch", fault_latched, 1'b0);
      chk("R9 inhibit released", hs_inhibit, 1'b0);
      chk("R12 pgood back", pgood, 1'b1);

      // R11: fault in the por clock wins
      do_reset();
      hs_strobe(1'b1);
      ot_trip = 1'b1; @(negedge clk); ot_trip = 1'b0;
      ot_release = 1'b1; @(negedge clk); ot_release = 1'b0;
      chk("R9 por before collision", por_pulse, 1'b1);
      hs_err = 1'b1; hs_sample = 1'b1;
      @(negedge clk);
      hs_err = 1'b0; hs_sample = 1'b0;
      chk("R11 set wins over por", fault_latched, 1'b1);
      chk("R9 por dropped", por_pulse, 1'b0);
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
      chk("R11 reset clears", fault_latched, 1'b0);

      // R10 / R12: enables
      for (int v = 0; v < 8; v++) begin
         sleep_ok = v[0]; reg_ok = v[1]; enable = v[2];
         @(negedge clk);
         chk("R10 termination enable", tt_enable, v[0] & v[1] & v[2]);
         chk("R12 pgood", pgood, v[1] & v[2]);
         chk("R12 enable inhibit", hs_inhibit, !v[2]);
      end

      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule